// File: doc/BRIEF.md
# Snooze power-down sequencer

This block controls a synchronous memory's low-power sleep state. A sleep request arrives on an asynchronous, active-high pin. The block synchronizes it, stops command sampling and, after a short drain window, forces the data outputs to high impedance. Stored contents are kept throughout. When the request drops, the block opens a short exit window before full operation resumes. During that window only reads and deselects are accepted.

The block sits between the command decoder and the array control. For every incoming command it reports whether the command may proceed. It gates the delayed data phase of a write that has already been accepted, and it raises a one-cycle violation flag when a write is refused for sequencing reasons. The drain and exit windows are fixed cycle counts set by parameters.

Top module: `snooze_seq`

## Requirements
- R1: After reset the block is awake: `in_en_o`=1, `out_hiz_o`=0, `viol_o`=0 and `wr_data_en_o`=0, and a read (`cmd_valid_i`=1, `cmd_wr_i`=0) gives `cmd_ok_o`=1.
- R2: `zz_i` passes through a two-flop synchronizer. `in_en_o` is still 1 after the first rising edge following a rise of `zz_i`, and it is 0 from the second edge on.
- R3: After sampling stops, the outputs stay driven for ENTER_CYC (default 2) further cycles. Then `out_hiz_o` goes to 1 and stays there while the request is held.
- R4: While sampling is stopped, every command is refused (`cmd_ok_o`=0). A write offered in that time produces no `wr_data_en_o` and no `viol_o`.
- R5: After `zz_i` falls, `out_hiz_o` is still 1 after the second edge. From the third edge on, `out_hiz_o`=0 and `in_en_o`=1.
- R6: For EXIT_CYC (default 2) cycles after wake-up, reads are accepted and writes are refused. After that window, writes are accepted again.
- R7: A write (`cmd_valid_i`=1, `cmd_wr_i`=1) offered during the exit window sets `viol_o` for exactly the one cycle after it.
- R8: An accepted write (`cmd_ok_o`=1 with `cmd_wr_i`=1) raises `wr_data_en_o` in the following cycle.
- R9: A write accepted in the cycle just before the synchronized request rises loses its data phase (`wr_data_en_o` stays 0), and `viol_o` is 1 for one cycle after that data-phase cycle.
- R10: A request that rises again during the exit window sends the block back through the drain window into sleep, with no return to full operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zz_i | input | 1 | Asynchronous sleep request, active high |
| cmd_valid_i | input | 1 | A decoded read or write is offered this cycle (0 = deselect) |
| cmd_wr_i | input | 1 | 1 = write, 0 = read; valid with `cmd_valid_i` |
| in_en_o | output | 1 | Command inputs are being sampled |
| out_hiz_o | output | 1 | Data outputs forced to high impedance |
| cmd_ok_o | output | 1 | The offered command may proceed |
| wr_data_en_o | output | 1 | The delayed write data phase may be stored this cycle |
| viol_o | output | 1 | One-cycle pulse: a write was refused or aborted by sequencing |

## Verification
If the window counters or the state register hold a wrong value, the edge on which `out_hiz_o` or `in_en_o` changes moves. The bench pins that edge down exactly, counting from the synchronizer input, so an error of one cycle is caught the cycle it happens. If the exit state is wrong, a write is accepted or refused on the wrong side of the window, and `cmd_ok_o` shows it in the same cycle. A wrong pending-write flag shows on `wr_data_en_o` one cycle later and on `viol_o` the cycle after that.

// File: rtl/snooze_pkg.sv
package snooze_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } snz_state_e;
endpackage

// File: rtl/snooze_sync.sv
module snooze_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/snooze_fsm.sv
module snooze_fsm
  import snooze_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned EXIT_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zz_sync_i,
  output logic in_en_o,
  output logic out_hiz_o,
  output logic wake_win_o
);
  localparam int unsigned MAX_CYC = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CW-1:0] ENTER_LD = CW'(ENTER_CYC - 1);
  localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);

  snz_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_AWAKE: if (zz_sync_i) begin
        st_d  = ST_DRAIN;
        cnt_d = ENTER_LD;
      end
      ST_DRAIN: begin
        if (cnt_q == '0) st_d = ST_SLEEP;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_SLEEP: if (!zz_sync_i) begin
        st_d  = ST_WAKE;
        cnt_d = EXIT_LD;
      end
      ST_WAKE: begin
        if (zz_sync_i) begin
          st_d  = ST_DRAIN;
          cnt_d = ENTER_LD;
        end else if (cnt_q == '0) begin
          st_d = ST_AWAKE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign in_en_o    = ((st_q == ST_AWAKE) || (st_q == ST_WAKE)) && !zz_sync_i;
  assign out_hiz_o  = (st_q == ST_SLEEP);
  assign wake_win_o = (st_q == ST_WAKE);
endmodule

// File: rtl/snooze_guard.sv
module snooze_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_wr_i,
  input  logic in_en_i,
  input  logic wake_win_i,
  input  logic zz_sync_i,
  output logic cmd_ok_o,
  output logic wr_data_en_o,
  output logic viol_o
);
  logic wr_take, wr_bad, pend_q, viol_q;

  assign wr_take  = cmd_valid_i && cmd_wr_i && in_en_i && !wake_win_i;
  // write during the exit window: refused and flagged
  assign wr_bad   = cmd_valid_i && cmd_wr_i && in_en_i && wake_win_i;
  assign cmd_ok_o = cmd_valid_i && in_en_i && (!cmd_wr_i || !wake_win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      pend_q <= wr_take;
      viol_q <= wr_bad || (pend_q && zz_sync_i);
    end
  end

  assign wr_data_en_o = pend_q && !zz_sync_i;
  assign viol_o       = viol_q;
endmodule

// File: rtl/snooze_seq.sv
module snooze_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ENTER_CYC   = 2,
  parameter int unsigned EXIT_CYC    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zz_i,
  input  logic cmd_valid_i,
  input  logic cmd_wr_i,
  output logic in_en_o,
  output logic out_hiz_o,
  output logic cmd_ok_o,
  output logic wr_data_en_o,
  output logic viol_o
);
  logic zz_sync, wake_win;

  snooze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (zz_i),
    .q_o   (zz_sync)
  );

  snooze_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zz_sync_i (zz_sync),
    .in_en_o   (in_en_o),
    .out_hiz_o (out_hiz_o),
    .wake_win_o(wake_win)
  );

  snooze_guard u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_wr_i    (cmd_wr_i),
    .in_en_i     (in_en_o),
    .wake_win_i  (wake_win),
    .zz_sync_i   (zz_sync),
    .cmd_ok_o    (cmd_ok_o),
    .wr_data_en_o(wr_data_en_o),
    .viol_o      (viol_o)
  );
endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_wr_i,
  input logic in_en_o,
  input logic out_hiz_o,
  input logic cmd_ok_o,
  input logic wr_data_en_o,
  input logic viol_o
);
  logic acc_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) acc_q <= 1'b0;
    else         acc_q <= cmd_ok_o && cmd_wr_i;

  // R4
  hiz_no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hiz_o |-> (!cmd_ok_o && !in_en_o));

  // R8
  wdata_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_en_o |-> acc_q);

  // R9
  abort_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && !wr_data_en_o) |=> viol_o);

  // R7
  viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past((in_en_o && cmd_valid_i && cmd_wr_i && !cmd_ok_o) ||
                     (acc_q && !wr_data_en_o)));

  // R6
  wake_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_hiz_o) |-> !(cmd_ok_o && cmd_wr_i));
endmodule

bind snooze_seq snooze_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_wr_i    (cmd_wr_i),
  .in_en_o     (in_en_o),
  .out_hiz_o   (out_hiz_o),
  .cmd_ok_o    (cmd_ok_o),
  .wr_data_en_o(wr_data_en_o),
  .viol_o      (viol_o)
);

// File: tb/snooze_seq_test.sv
`timescale 1ns/1ps
module snooze_seq_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic zz_i = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_wr_i = 1'b0;
  logic in_en_o, out_hiz_o, cmd_ok_o, wr_data_en_o, viol_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  snooze_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .zz_i(zz_i),
    .cmd_valid_i(cmd_valid_i), .cmd_wr_i(cmd_wr_i),
    .in_en_o(in_en_o), .out_hiz_o(out_hiz_o), .cmd_ok_o(cmd_ok_o),
    .wr_data_en_o(wr_data_en_o), .viol_o(viol_o)
  );

  task automatic check(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // advance one edge, land 2 ns after it
  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic drive(logic v, logic w);
    cmd_valid_i = v;
    cmd_wr_i    = w;
    #0.5;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    check("R1", "in_en", in_en_o, 1'b1);
    check("R1", "out_hiz", out_hiz_o, 1'b0);
    check("R1", "viol", viol_o, 1'b0);
    check("R1", "wr_data_en", wr_data_en_o, 1'b0);
    drive(1'b1, 1'b0);
    check("R1", "read ok", cmd_ok_o, 1'b1);
    drive(1'b0, 1'b0);
  endtask

  task automatic t_awake_write();
    drive(1'b1, 1'b1);
    check("R8", "write ok", cmd_ok_o, 1'b1);
    tick();
    drive(1'b0, 1'b0);
    check("R8", "data phase", wr_data_en_o, 1'b1);
    tick();
    check("R8", "data phase ends", wr_data_en_o, 1'b0);
  endtask

  task automatic t_enter();
    zz_i = 1'b1;
    tick();
    check("R2", "in_en after 1st edge", in_en_o, 1'b1);
    tick();
    check("R2", "in_en after 2nd edge", in_en_o, 1'b0);
    drive(1'b1, 1'b0);
    check("R4", "read refused", cmd_ok_o, 1'b0);
    drive(1'b0, 1'b0);
    tick();
    check("R3", "driven drain 1", out_hiz_o, 1'b0);
    tick();
    check("R3", "driven drain 2", out_hiz_o, 1'b0);
    tick();
    check("R3", "hiz", out_hiz_o, 1'b1);
  endtask

  task automatic t_sleep_ignore();
    drive(1'b1, 1'b1);
    check("R4", "write refused", cmd_ok_o, 1'b0);
    tick();
    check("R4", "no data phase", wr_data_en_o, 1'b0);
    check("R4", "no viol", viol_o, 1'b0);
    drive(1'b0, 1'b0);
    tick();
    check("R3", "hiz held", out_hiz_o, 1'b1);
  endtask

  task automatic t_exit();
    zz_i = 1'b0;
    tick();
    check("R5", "hiz after 1st edge", out_hiz_o, 1'b1);
    tick();
    check("R5", "hiz after 2nd edge", out_hiz_o, 1'b1);
    tick();
    check("R5", "hiz cleared", out_hiz_o, 1'b0);
    check("R5", "in_en back", in_en_o, 1'b1);
    drive(1'b1, 1'b0);
    check("R6", "read in exit window", cmd_ok_o, 1'b1);
    drive(1'b1, 1'b1);
    check("R6", "write in exit window", cmd_ok_o, 1'b0);
    tick();
    drive(1'b0, 1'b0);
    check("R7", "viol set", viol_o, 1'b1);
    check("R7", "no data phase", wr_data_en_o, 1'b0);
    tick();
    check("R7", "viol one cycle", viol_o, 1'b0);
    drive(1'b1, 1'b1);
    check("R6", "write after window", cmd_ok_o, 1'b1);
    tick();
    drive(1'b0, 1'b0);
    check("R8", "data phase after window", wr_data_en_o, 1'b1);
    tick();
  endtask

  task automatic t_abort();
    zz_i = 1'b1;
    tick();
    drive(1'b1, 1'b1);
    check("R9", "write taken before sync", cmd_ok_o, 1'b1);
    tick();
    drive(1'b0, 1'b0);
    check("R9", "data phase killed", wr_data_en_o, 1'b0);
    tick();
    check("R9", "viol set", viol_o, 1'b1);
    tick();
    check("R9", "viol one cycle", viol_o, 1'b0);
    tick();
    check("R3", "hiz after abort", out_hiz_o, 1'b1);
  endtask

  task automatic t_reenter();
    zz_i = 1'b0;
    tick();
    tick();
    zz_i = 1'b1;
    tick();
    check("R10", "wake window open", in_en_o, 1'b1);
    tick();
    check("R10", "sampling stops", in_en_o, 1'b0);
    tick();
    check("R10", "no full wake", in_en_o, 1'b0);
    tick();
    tick();
    check("R10", "back asleep", out_hiz_o, 1'b1);
    zz_i = 1'b0;
    repeat (6) tick();
    drive(1'b1, 1'b1);
    check("R6", "write after final wake", cmd_ok_o, 1'b1);
    drive(1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_awake_write();
    t_enter();
    t_sleep_ignore();
    t_exit();
    t_abort();
    t_reenter();
    tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule